// File: doc/BRIEF.md
# I2C Serial Memory Slave Protocol Engine

This block is the bus-facing engine of a byte-addressed serial memory that answers the common two-wire memory protocol. It runs on a system clock. SCL and SDA reach it already synchronised. It finds start and stop conditions and frames each byte as eight data clocks plus an acknowledge clock. It accepts only device address `1010_000` and answers with a pull-low enable for an open-drain SDA pad.

A write header is followed by a two-byte word address, and that address loads a 13-bit internal pointer. Any data bytes that follow are passed, one strobe per byte, to a separate page-write controller. A stop that follows at least one data byte starts the commit. Reads fetch bytes from an 8K x 8 synchronous memory port with one cycle of latency. They are sent MSB first, and the block keeps sending while the master acknowledges. A random read is a write header and word address with no data, then a repeated start with the read bit set. While the page-write controller reports a write cycle in progress, the device address is refused, so the master can poll for the end of the write.

Top module: `ee_i2c_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start at any bit position drops the frame in progress and begins a new device-address byte.
- R2: The first byte after a start is acknowledged, with a pull-low in the ninth clock, only when its upper seven bits equal `1010000`. Any other value gets no pull-low, and the block ignores the bus until the next start.
- R3: After an acknowledged write header, two address bytes follow, and both are acknowledged. The top three bits of the first byte are ignored. The low five bits of the first byte become pointer bits 12..8, and the second byte becomes bits 7..0.
- R4: Each data byte after the word address is acknowledged and sent out as one `wr_valid_o` strobe carrying the pointer and the byte. `wr_first_o` is 1 only on the first byte of a transfer. `wr_commit_o` pulses on a stop only if at least one data byte came in since the last start. A stop in the address phase, or a repeated start after data, gives no commit.
- R5: During a write, only pointer bits 4..0 advance after each data byte, wrapping inside the 32-byte page. Bits 12..5 stay unchanged.
- R6: A read sends the byte at the pointer, MSB first. When the master acknowledges with 0, the pointer advances and the next byte is sent.
- R7: During reads, the pointer wraps from 0x1FFF to 0x0000.
- R8: After any transfer, the pointer holds the last accessed address plus one, with read or page wrap applied. A current-address read starts from that value.
- R9: While `wr_busy_i` is 1, the device address is not acknowledged, whatever the read/write bit.
- R10: `sda_pull_o` changes only in the cycle after a detected SCL falling edge, start or stop.
- R11: After a master NACK on read data, SDA is released, and the block drives nothing on further clocks until the next start or stop.
- R12: Each byte sent causes exactly one single-cycle `mem_rd_en_o` pulse, issued at the start of the acknowledge slot before that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the request |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | 13 | Memory read address |
| wr_valid_o | output | 1 | One write byte is available |
| wr_first_o | output | 1 | This write byte is the first of the transfer |
| wr_addr_o | output | 13 | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | A stop ended a write that carried data |

## Verification
Edges on SCL are seen one system clock after they happen. `sda_pull_o` therefore settles one clock after the SCL fall that starts an acknowledge slot or a data bit. The bench always samples the bus two clocks into the SCL high phase, well after that update. A read request leaves one clock after the acknowledge slot opens. The byte is captured two clocks after that, well before the slot's closing fall that puts the MSB on SDA, so the bench compares each read bit against the expected byte for the address it predicts. Write strobes and commit pulses are registered, and the bench counts them in a monitor on every clock. Those counts are compared only after the stop or restart, or after the whole transfer has ended.

// File: rtl/ee_slv_pkg.sv
package ee_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } ee_state_e;
endpackage

// File: rtl/ee_line_mon.sv
module ee_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_bit_frame.sv
module ee_bit_frame #(
  parameter int unsigned BW = 8,
  parameter int unsigned CW = $clog2(BW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  output logic [CW-1:0] cnt_o,
  output logic [BW-1:0] rx_o,
  output logic          ack_phase_o,
  output logic          ack_begin_o,
  output logic          ack_end_o,
  output logic          ack_rise_o
);
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] rx_q;
  logic          ack_q;
  logic          full;

  assign full        = (cnt_q == CW'(BW));
  assign ack_begin_o = scl_fall_i & full & ~ack_q;
  assign ack_end_o   = scl_fall_i & ack_q;
  assign ack_rise_o  = scl_rise_i & ack_q;
  assign cnt_o       = cnt_q;
  assign rx_o        = rx_q;
  assign ack_phase_o = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
      ack_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      if (scl_rise_i && !ack_q && !full) begin
        rx_q  <= {rx_q[BW-2:0], sda_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (ack_begin_o) ack_q <= 1'b1;
      if (ack_end_o) begin
        ack_q <= 1'b0;
        cnt_q <= '0;
      end
    end
  end

  // R1
  ack_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (cnt_q == CW'(BW)));
  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(BW));
endmodule

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int unsigned AW = 13,
  parameter int unsigned PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_full_i,
  input  logic          inc_page_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] ptr_next_o
);
  logic [AW-1:0] ptr_q;
  logic [PW-1:0] page_lo;

  assign ptr_next_o = ptr_q + 1'b1;
  assign page_lo    = ptr_q[PW-1:0] + 1'b1;
  assign ptr_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (load_i)     ptr_q <= load_val_i;
    else if (inc_page_i) ptr_q <= {ptr_q[AW-1:PW], page_lo};
    else if (inc_full_i) ptr_q <= ptr_next_o;
  end

  // R5
  page_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_page_i && !load_i) |=> (ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])));
  // R7
  read_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_full_i && !load_i && !inc_page_i && (ptr_q == {AW{1'b1}})) |=> (ptr_q == '0));
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_slv_pkg::*;
#(
  parameter int unsigned AW       = 13,
  parameter int unsigned DW       = 8,
  parameter int unsigned PW       = 5,
  parameter logic [3:0]  DEV_CODE = 4'b1010,
  parameter logic [2:0]  SLV_SEL  = 3'b000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          wr_busy_i,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          sda_pull_o,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_rd_addr_o,
  output logic          wr_valid_o,
  output logic          wr_first_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_commit_o
);
  localparam int unsigned HW = AW - DW;
  localparam int unsigned CW = $clog2(DW + 1);

  logic scl_rise, scl_fall, start_c, stop_c;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx;
  logic ack_phase, ack_begin, ack_end, ack_rise;
  logic clr;

  ee_state_e     state_q;
  logic [DW-1:0] tx_q;
  logic [HW-1:0] hi_q;
  logic          rw_q, m_ack_q, wr_seen_q, rd_en_q, rd_pend_q, pull_q;
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic          wr_valid_q, wr_first_q, commit_q;

  logic          ld, inc_full, inc_page, dev_hit, quiet;
  logic [AW-1:0] ptr, ptr_nx;

  ee_line_mon u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  assign clr = start_c | stop_c | (state_q == ST_IDLE);

  ee_bit_frame #(.BW(DW), .CW(CW)) u_frm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clr),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_i),
    .cnt_o      (cnt),
    .rx_o       (rx),
    .ack_phase_o(ack_phase),
    .ack_begin_o(ack_begin),
    .ack_end_o  (ack_end),
    .ack_rise_o (ack_rise)
  );

  assign quiet   = ~start_c & ~stop_c;
  assign dev_hit = (rx[DW-1:1] == {DEV_CODE, SLV_SEL}) & ~wr_busy_i;

  always_comb begin
    ld       = 1'b0;
    inc_full = 1'b0;
    inc_page = 1'b0;
    if (quiet && ack_begin) begin
      unique case (state_q)
        ST_ALO:  ld       = 1'b1;
        ST_WDAT: inc_page = 1'b1;
        ST_RDAT: inc_full = 1'b1;
        default: ;
      endcase
    end
  end

  ee_addr_ptr #(.AW(AW), .PW(PW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld),
    .load_val_i({hi_q, rx}),
    .inc_full_i(inc_full),
    .inc_page_i(inc_page),
    .ptr_o     (ptr),
    .ptr_next_o(ptr_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tx_q       <= '0;
      hi_q       <= '0;
      rw_q       <= 1'b0;
      m_ack_q    <= 1'b0;
      wr_seen_q  <= 1'b0;
      rd_en_q    <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_addr_q  <= '0;
      pull_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_first_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      commit_q   <= 1'b0;
    end else begin
      rd_en_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      rd_pend_q  <= rd_en_q;
      if (rd_pend_q) tx_q <= mem_rd_data_i;

      if (start_c) begin
        state_q   <= ST_DEV;
        pull_q    <= 1'b0;
        wr_seen_q <= 1'b0;
      end else if (stop_c) begin
        state_q   <= ST_IDLE;
        pull_q    <= 1'b0;
        commit_q  <= wr_seen_q;
        wr_seen_q <= 1'b0;
      end else if (ack_begin) begin
        unique case (state_q)
          ST_DEV: begin
            if (dev_hit) begin
              pull_q <= 1'b1;
              rw_q   <= rx[0];
              if (rx[0]) begin
                rd_en_q   <= 1'b1;
                rd_addr_q <= ptr;
              end
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          ST_AHI: begin
            pull_q <= 1'b1;
            hi_q   <= rx[HW-1:0];
          end
          ST_ALO: pull_q <= 1'b1;
          ST_WDAT: begin
            pull_q     <= 1'b1;
            wr_valid_q <= 1'b1;
            wr_addr_q  <= ptr;
            wr_data_q  <= rx;
            wr_first_q <= ~wr_seen_q;
            wr_seen_q  <= 1'b1;
          end
          ST_RDAT: begin
            pull_q    <= 1'b0;
            rd_en_q   <= 1'b1;
            rd_addr_q <= ptr_nx;
          end
          default: pull_q <= 1'b0;
        endcase
      end else if (ack_rise) begin
        m_ack_q <= ~sda_i;
      end else if (ack_end) begin
        unique case (state_q)
          ST_DEV: begin
            if (rw_q) begin
              state_q <= ST_RDAT;
              pull_q  <= ~tx_q[DW-1];
              tx_q    <= tx_q << 1;
            end else begin
              state_q <= ST_AHI;
              pull_q  <= 1'b0;
            end
          end
          ST_AHI:  begin state_q <= ST_ALO;  pull_q <= 1'b0; end
          ST_ALO:  begin state_q <= ST_WDAT; pull_q <= 1'b0; end
          ST_RDAT: begin
            if (m_ack_q) begin
              pull_q <= ~tx_q[DW-1];
              tx_q   <= tx_q << 1;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          default: pull_q <= 1'b0;
        endcase
      end else if (scl_fall && state_q == ST_RDAT && !ack_phase && cnt != '0) begin
        pull_q <= ~tx_q[DW-1];
        tx_q   <= tx_q << 1;
      end
    end
  end

  assign sda_pull_o    = pull_q;
  assign mem_rd_en_o   = rd_en_q;
  assign mem_rd_addr_o = rd_addr_q;
  assign wr_valid_o    = wr_valid_q;
  assign wr_first_o    = wr_first_q;
  assign wr_addr_o     = wr_addr_q;
  assign wr_data_o     = wr_data_q;
  assign wr_commit_o   = commit_q;

  // R10
  pull_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> $past(scl_fall | start_c | stop_c));
  // R9
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_begin && quiet && state_q == ST_DEV && wr_busy_i) |=> !sda_pull_o);
  // R4
  wr_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(state_q == ST_WDAT));
  // R12
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_en_o |=> !mem_rd_en_o);
  // R11
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_pull_o);
endmodule

// File: tb/ee_i2c_slave_tb_top.sv
module ee_i2c_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, rd_en, wr_valid, wr_first, wr_commit;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic busy;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  ee_i2c_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wr_busy_i(busy), .mem_rd_data_i(rd_data), .sda_pull_o(sda_pull),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .wr_valid_o(wr_valid),
    .wr_first_o(wr_first), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] mem_f(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_f(rd_addr);

  int wn = 0, commits = 0, busy_cnt = 0, rd_pulses = 0;
  logic [12:0] wa [64];
  logic [7:0]  wd [64];
  logic        wf [64];
  assign busy = (busy_cnt != 0);
  always_ff @(posedge clk) begin
    if (rd_en) rd_pulses <= rd_pulses + 1;
    if (wr_valid && wn < 64) begin
      wa[wn] <= wr_addr; wd[wn] <= wr_data; wf[wn] <= wr_first;
      wn <= wn + 1;
    end
    if (wr_commit) begin commits <= commits + 1; busy_cnt <= 400; end
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(2); scl_m = 1'b1; tick(4); sda_m = 1'b1; tick(4);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(2); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(2);
    ack = ~sda_bus;
    tick(2); scl_m = 1'b0; tick(2);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2); scl_m = 1'b1; tick(2); b[i] = sda_bus; tick(2); scl_m = 1'b0;
    end
    tick(2); sda_m = ~mack; tick(2); scl_m = 1'b1; tick(4); scl_m = 1'b0;
    tick(2); sda_m = 1'b1;
  endtask

  // write header plus word address, then repeated start with a read header
  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    send_byte(8'hA0, a); check(a, "R3 hdr", a, 1);
    send_byte(hi, a);    check(a, "R3 hi", a, 1);
    send_byte(lo, a);    check(a, "R3 lo", a, 1);
    bus_start();
    send_byte(8'hA1, a); check(a, "R6 rdhdr", a, 1);
  endtask

  task automatic cur_read(input logic [12:0] exp_a, input string tag);
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hA1, a); check(a, tag, a, 1);
    read_byte(1'b0, d);  check(d == mem_f(exp_a), tag, d, mem_f(exp_a));
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] d;
    logic [12:0] exp_ptr;
    int wn0, cm0, rp0;
    bit any_pull;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // reset state
    check(sda_pull == 1'b0, "R10 reset pull", sda_pull, 0);
    check(rd_pulses == 0, "R12 reset rd", rd_pulses, 0);
    check(wn == 0 && commits == 0, "R4 reset wr", wn, 0);

    // R2: all 256 first bytes
    exp_ptr = '0;
    for (int b = 0; b < 256; b++) begin
      bit exp_ack;
      exp_ack = (b[7:1] == 7'h50);
      bus_start();
      rp0 = rd_pulses;
      send_byte(8'(b), a);
      check(a == exp_ack, "R2 dev match", a, exp_ack);
      if (a && b[0]) begin
        read_byte(1'b0, d);
        check(d == mem_f(exp_ptr), "R6 R8 current read", d, mem_f(exp_ptr));
        check(rd_pulses - rp0 == 2, "R12 one request per slot", rd_pulses - rp0, 2);
        exp_ptr = exp_ptr + 1'b1;
      end
      bus_stop();
    end
    check(wn == 0 && commits == 0, "R4 no commit without data", commits, 0);

    // R3 ignored high bits, R6 sequential, R8 follow-on
    set_ptr(8'hE3, 8'h45);
    for (int k = 0; k < 4; k++) begin
      read_byte(k != 3, d);
      check(d == mem_f(13'h0345 + 13'(k)), "R6 sequential", d, mem_f(13'h0345 + 13'(k)));
    end
    bus_stop();
    cur_read(13'h0349, "R8 after seq");

    // R7 wrap
    set_ptr(8'h1F, 8'hFE);
    for (int k = 0; k < 3; k++) begin
      read_byte(k != 2, d);
      check(d == mem_f(13'h1FFE + 13'(k)), "R7 wrap", d, mem_f(13'h1FFE + 13'(k)));
    end
    bus_stop();
    cur_read(13'h0001, "R7 R8 after wrap");

    // R11 release after master NACK
    set_ptr(8'h00, 8'h10);
    read_byte(1'b0, d);
    check(d == mem_f(13'h0010), "R11 read", d, mem_f(13'h0010));
    any_pull = 1'b0;
    for (int k = 0; k < 9; k++) begin
      tick(2); scl_m = 1'b1; tick(2);
      if (!sda_bus) any_pull = 1'b1;
      tick(2); scl_m = 1'b0; tick(2);
    end
    check(!any_pull, "R11 silent after nack", any_pull, 0);
    bus_stop();
    cur_read(13'h0011, "R11 R8 ptr after nack");

    // R1 restart mid device byte, then mid address byte
    bus_start();
    send_bits(8'hA0, 4);
    set_ptr(8'h01, 8'h23);
    read_byte(1'b0, d);
    check(d == mem_f(13'h0123), "R1 restart in dev", d, mem_f(13'h0123));
    bus_stop();
    bus_start();
    send_byte(8'hA0, a); check(a, "R1 hdr", a, 1);
    send_bits(8'h1F, 3);
    bus_start();
    send_byte(8'hA1, a); check(a, "R1 restart in addr", a, 1);
    read_byte(1'b0, d);
    check(d == mem_f(13'h0124), "R1 R8 ptr kept", d, mem_f(13'h0124));
    bus_stop();

    // R4 stop inside the address phase
    wn0 = wn; cm0 = commits;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'h01, a);
    bus_stop();
    tick(2);
    check(wn == wn0 && commits == cm0, "R4 stop in address", commits - cm0, 0);
    cur_read(13'h0125, "R3 ptr not loaded");

    // R4 R5 page write with page wrap
    wn0 = wn; cm0 = commits;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'h0A, a);
    send_byte(8'h1E, a);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h11 * 8'(k + 1), a);
      check(a, "R4 data ack", a, 1);
    end
    bus_stop();
    tick(2);
    check(wn - wn0 == 4, "R4 strobes", wn - wn0, 4);
    check(commits - cm0 == 1, "R4 commit", commits - cm0, 1);
    for (int k = 0; k < 4; k++) begin
      logic [12:0] ea;
      ea = {8'h50, 5'(5'h1E + 5'(k))};
      check(wa[wn0 + k] == ea, "R5 page addr", wa[wn0 + k], ea);
      check(wd[wn0 + k] == 8'h11 * 8'(k + 1), "R4 data", wd[wn0 + k], 8'h11 * 8'(k + 1));
      check(wf[wn0 + k] == (k == 0), "R4 first flag", wf[wn0 + k], k == 0);
    end

    // R9 polling while busy
    bus_start();
    send_byte(8'hA0, a); check(!a, "R9 busy nack write", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA1, a); check(!a, "R9 busy nack read", a, 0);
    bus_stop();
    tick(450);
    cur_read(13'h0A02, "R9 R5 R8 after write");

    // R4 repeated start after data: strobe but no commit
    wn0 = wn; cm0 = commits;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    send_byte(8'h5A, a);
    bus_start();
    send_byte(8'hA1, a);
    read_byte(1'b0, d);
    check(d == mem_f(13'h0041), "R8 read after restart", d, mem_f(13'h0041));
    bus_stop();
    tick(2);
    check(wn - wn0 == 1 && wf[wn0], "R4 single strobe", wn - wn0, 1);
    check(commits == cm0, "R4 restart no commit", commits - cm0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule